// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address by following a two-level translation structure held in memory. A request carries the linear address; the base of the top-level directory comes from a root register value that the surrounding logic holds on an input. The walker makes two dependent reads through one memory read port. The first fetches a directory entry, which points to a page table. The second fetches a page-table entry, which points to a 4 KB page frame.

When the walk ends, the block raises a one-cycle completion pulse. It also presents either the physical address or a page-fault flag. A fault is reported when the entry at either level has its present flag clear. Only one walk is in flight at a time. The block takes a new linear address only while idle, and the memory port may answer after any number of wait cycles.

Top module: `ptw_walker`

## Requirements
- R1: After a synchronous active-low reset, req_ready is 1 and mem_req, done, page_fault and paddr are all 0.
- R2: The first read of a walk is at address {root[31:12], la[31:22], 2'b00}, where root is the root_base value sampled when the request is accepted; root bits 11:0 play no part.
- R3: When the directory entry has bit 0 set, the second read is at address {dir_entry[31:12], la[21:12], 2'b00}; bits 11:1 of the directory entry play no part.
- R4: When both entries have bit 0 set, paddr equals {table_entry[31:12], la[11:0]} and page_fault is 0 while done is high.
- R5: When the directory entry has bit 0 clear, the walk makes exactly one read and ends with page_fault 1 and paddr 0.
- R6: When the table entry has bit 0 clear, the walk makes exactly two reads and ends with page_fault 1 and paddr 0.
- R7: req_ready is 1 only while the walker is idle; req_valid and req_laddr presented during a walk are not taken and cause no extra read.
- R8: mem_req stays high with an unchanged mem_addr until the cycle in which mem_ack is high; mem_rdata is taken in that cycle, and any latency from zero wait cycles upward is handled.
- R9: done is high for exactly one cycle per walk, and req_ready is 1 in the cycle after done.
- R10: Changes to root_base after a request is accepted have no effect on that walk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_laddr | input | 32 | Linear address to translate |
| root_base | input | 32 | Directory base; upper 20 bits used |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_ack | input | 1 | Read completes; mem_rdata valid this cycle |
| mem_rdata | input | 32 | Entry word returned by memory |
| done | output | 1 | One-cycle pulse: walk finished |
| page_fault | output | 1 | Walk hit a non-present entry; valid with done |
| paddr | output | 32 | Translated physical address; valid with done |

## Verification
Every cycle, the embedded assertions check the memory handshake discipline: the request is held steady until it is acknowledged, and it never overlaps with req_ready. They also check that done is a single pulse followed by idle, that the sampled root stays stable through a walk, and that a fault always comes with a zero address. Only the bench scenarios can show that the addresses of both reads and the final physical address are arithmetically correct. The same holds for stopping after one read on a directory miss, and for root or request changes during a walk having no effect. The sweep covers all 1024 directory indices under zero to three wait cycles.

// File: rtl/ptw_pkg.sv
// Package: shared state encoding for the page-table walker.
// Assumes: imported by every walker module; no parameters live here.
package ptw_pkg;

    // Walk sequencer states; order is the normal progression of a walk.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RD_DIR = 3'd1,
        ST_WT_DIR = 3'd2,
        ST_RD_TBL = 3'd3,
        ST_WT_TBL = 3'd4,
        ST_DONE   = 3'd5
    } walk_state_e;

    // Byte shift that turns an entry index into a byte offset (4-byte entries).
    localparam int ENTRY_SHIFT = 2;

endpackage

// File: rtl/ptw_ctrl.sv
// Module: ptw_ctrl
// Sequences one walk: takes a request while idle, issues the directory read,
// then the table read, and finishes with a one-cycle done state.
// Assumes: mem_ack is only meaningful while mem_req is high; the present flag
// of the returned word is supplied on entry_present in the ack cycle.
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        mem_ack,
    input  logic        entry_present,
    output logic        accept_o,
    output logic        dir_good_o,
    output logic        tbl_good_o,
    output logic        fault_o,
    output logic        tbl_phase_o,
    output logic        req_ready_o,
    output logic        mem_req_o,
    output logic        done_o
);

    walk_state_e state_q;
    walk_state_e state_d;
    logic        dir_phase;
    logic        dir_take;
    logic        tbl_take;

    // Phase decode from the current state.
    always_comb begin
        dir_phase   = (state_q == ST_RD_DIR) || (state_q == ST_WT_DIR);
        tbl_phase_o = (state_q == ST_RD_TBL) || (state_q == ST_WT_TBL);
        dir_take    = dir_phase && mem_ack;
        tbl_take    = tbl_phase_o && mem_ack;
    end

    // Strobes to the datapath and port-level outputs.
    always_comb begin
        req_ready_o = (state_q == ST_IDLE);
        accept_o    = req_ready_o && req_valid;
        mem_req_o   = dir_phase || tbl_phase_o;
        done_o      = (state_q == ST_DONE);
        dir_good_o  = dir_take && entry_present;
        tbl_good_o  = tbl_take && entry_present;
        fault_o     = (dir_take || tbl_take) && !entry_present;
    end

    // Next-state selection for the walk sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_RD_DIR;
            ST_RD_DIR: begin
                if (mem_ack) state_d = entry_present ? ST_RD_TBL : ST_DONE;
                else         state_d = ST_WT_DIR;
            end
            ST_WT_DIR: if (mem_ack) state_d = entry_present ? ST_RD_TBL : ST_DONE;
            ST_RD_TBL: begin
                if (mem_ack) state_d = ST_DONE;
                else         state_d = ST_WT_TBL;
            end
            ST_WT_TBL: if (mem_ack) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack) |=> mem_req_o); // R8
    AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |=> (state_q == ST_IDLE)); // R9
    AST_ONE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dir_take, tbl_take, accept_o})); // R7

endmodule

// File: rtl/ptw_addr_gen.sv
// Module: ptw_addr_gen
// Holds the request fields for the walk in progress and forms the byte address
// of the directory entry or the table entry.
// Assumes: DIR_W + ENTRY_SHIFT == OFF_W and TBL_W + ENTRY_SHIFT == OFF_W, so
// each level fits exactly in one 4 KB-aligned page of 4-byte entries.
module ptw_addr_gen
    import ptw_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DIR_W = 10,
    parameter int TBL_W = 10,
    parameter int OFF_W = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          dir_good,
    input  logic          tbl_phase,
    input  logic [AW-1:0] req_laddr,
    input  logic [AW-1:0] root_base,
    input  logic [AW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [OFF_W-1:0] offset_o
);

    localparam int FRAME_W = AW - OFF_W;
    localparam int TBL_LO  = OFF_W;
    localparam int TBL_HI  = OFF_W + TBL_W - 1;
    localparam int DIR_LO  = OFF_W + TBL_W;
    localparam int DIR_HI  = OFF_W + TBL_W + DIR_W - 1;

    logic [AW-1:0]      laddr_q;
    logic [FRAME_W-1:0] root_frame_q;
    logic [FRAME_W-1:0] tbl_frame_q;
    logic [AW-1:0]      dir_entry_addr;
    logic [AW-1:0]      tbl_entry_addr;

    // Capture the request and the root frame at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            laddr_q      <= '0;
            root_frame_q <= '0;
        end else if (accept) begin
            laddr_q      <= req_laddr;
            root_frame_q <= root_base[AW-1:OFF_W];
        end
    end

    // Capture the page-table frame from a present directory entry.
    always_ff @(posedge clk) begin
        if (!rst_n)        tbl_frame_q <= '0;
        else if (dir_good) tbl_frame_q <= mem_rdata[AW-1:OFF_W];
    end

    // Entry addresses for both levels; low bits of bases are dropped.
    always_comb begin
        dir_entry_addr = {root_frame_q, laddr_q[DIR_HI:DIR_LO], {ENTRY_SHIFT{1'b0}}};
        tbl_entry_addr = {tbl_frame_q,  laddr_q[TBL_HI:TBL_LO], {ENTRY_SHIFT{1'b0}}};
        mem_addr       = tbl_phase ? tbl_entry_addr : dir_entry_addr;
        offset_o       = laddr_q[OFF_W-1:0];
    end

    AST_ROOT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(root_frame_q)); // R10
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(laddr_q)); // R7

endmodule

// File: rtl/ptw_result.sv
// Module: ptw_result
// Registers the outcome of a walk: the physical address from a present table
// entry, or a fault with a zero address. Values are held until the next request.
// Assumes: tbl_good and fault are never high together.
module ptw_result
    import ptw_pkg::*;
#(
    parameter int AW    = 32,
    parameter int OFF_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             tbl_good,
    input  logic             fault,
    input  logic [AW-1:0]    mem_rdata,
    input  logic [OFF_W-1:0] offset,
    output logic [AW-1:0]    paddr,
    output logic             page_fault
);

    // Clear on a new request, then load the translation or the fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paddr      <= '0;
            page_fault <= 1'b0;
        end else if (accept) begin
            paddr      <= '0;
            page_fault <= 1'b0;
        end else if (fault) begin
            paddr      <= '0;
            page_fault <= 1'b1;
        end else if (tbl_good) begin
            paddr      <= {mem_rdata[AW-1:OFF_W], offset};
            page_fault <= 1'b0;
        end
    end

    AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
        page_fault |-> (paddr == '0)); // R5
    AST_EXCLUSIVE_END: assert property (@(posedge clk) disable iff (!rst_n)
        !(tbl_good && fault)); // R6

endmodule

// File: rtl/ptw_walker.sv
// Module: ptw_walker (top)
// Two-level page table walker: 10-bit directory index, 10-bit table index,
// 12-bit offset; one outstanding walk; single read port with req/ack.
// Assumes: memory returns the entry in the cycle it raises mem_ack; bit 0 of
// every entry is its present flag.
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int AW          = 32,
    parameter int DIR_W       = 10,
    parameter int TBL_W       = 10,
    parameter int OFF_W       = 12,
    parameter int PRESENT_BIT = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_laddr,
    input  logic [AW-1:0] root_base,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_ack,
    input  logic [AW-1:0] mem_rdata,
    output logic          done,
    output logic          page_fault,
    output logic [AW-1:0] paddr
);

    logic             accept;
    logic             dir_good;
    logic             tbl_good;
    logic             fault;
    logic             tbl_phase;
    logic             entry_present;
    logic [OFF_W-1:0] offset;

    // Present flag of the word currently on the read data bus.
    always_comb entry_present = mem_rdata[PRESENT_BIT];

    ptw_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .mem_ack       (mem_ack),
        .entry_present (entry_present),
        .accept_o      (accept),
        .dir_good_o    (dir_good),
        .tbl_good_o    (tbl_good),
        .fault_o       (fault),
        .tbl_phase_o   (tbl_phase),
        .req_ready_o   (req_ready),
        .mem_req_o     (mem_req),
        .done_o        (done)
    );

    ptw_addr_gen #(
        .AW    (AW),
        .DIR_W (DIR_W),
        .TBL_W (TBL_W),
        .OFF_W (OFF_W)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .dir_good  (dir_good),
        .tbl_phase (tbl_phase),
        .req_laddr (req_laddr),
        .root_base (root_base),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .offset_o  (offset)
    );

    ptw_result #(
        .AW    (AW),
        .OFF_W (OFF_W)
    ) u_res (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .tbl_good   (tbl_good),
        .fault      (fault),
        .mem_rdata  (mem_rdata),
        .offset     (offset),
        .paddr      (paddr),
        .page_fault (page_fault)
    );

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> $stable(mem_addr)); // R8
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready)); // R9
    AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mem_req && !req_ready)); // R9

endmodule

// File: tb/ptw_walker_tb_top.sv
`timescale 1ns/1ps
module ptw_walker_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_laddr;
    logic [31:0] root_base;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack;
    logic [31:0] mem_rdata;
    logic        done;
    logic        page_fault;
    logic [31:0] paddr;

    int checks = 0;
    int errors = 0;
    int mdelay = 0;
    int mcnt   = 0;
    int nreads = 0;
    logic [31:0] rlog [2];
    bit finished = 0;

    always #2.5 clk = ~clk;

    ptw_walker dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_laddr(req_laddr), .root_base(root_base), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .page_fault(page_fault), .paddr(paddr)
    );

    // Memory image computed from the address; bit 0 is parity of the index bits.
    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[29:10] ^ 20'h5A5A5, a[12:2], ^a[11:2]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory responder: acknowledges after mdelay idle cycles of a request.
    initial begin
        mem_ack = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                mcnt = 0;
            end else if (mem_req) begin
                if (mcnt >= mdelay) begin
                    mem_ack = 1'b1;
                    mem_rdata = mem_word(mem_addr);
                    if (nreads < 2) rlog[nreads] = mem_addr;
                    nreads++;
                end else begin
                    mcnt++;
                end
            end
        end
    end

    // One walk with expected results computed from the requirements.
    task automatic walk(input logic [31:0] la, input logic [31:0] root, input int dly);
        logic [31:0] da, de, ta, te, exp_pa;
        bit exp_fault;
        int exp_reads;
        int cyc = 0;
        bit seen = 0;
        da = {root[31:12], la[31:22], 2'b00};
        de = mem_word(da);
        ta = {de[31:12], la[21:12], 2'b00};
        te = mem_word(ta);
        if (!de[0]) begin exp_fault = 1; exp_reads = 1; exp_pa = 0; end
        else if (!te[0]) begin exp_fault = 1; exp_reads = 2; exp_pa = 0; end
        else begin exp_fault = 0; exp_reads = 2; exp_pa = {te[31:12], la[11:0]}; end

        @(negedge clk);
        chk(req_ready == 1'b1, "R9 ready before request", {31'd0, req_ready}, 32'd1);
        mdelay = dly;
        nreads = 0;
        req_valid = 1'b1;
        req_laddr = la;
        root_base = root;
        @(negedge clk);
        // R7/R10: keep offering a different request and root during the walk.
        req_laddr = ~la;
        root_base = ~root;
        while (!seen && cyc < 60) begin
            if (done) seen = 1;
            else begin
                chk(req_ready == 1'b0, "R7 ready low while busy", {31'd0, req_ready}, 32'd0);
                @(negedge clk);
                cyc++;
            end
        end
        req_valid = 1'b0;
        chk(seen, "R9 done reached", {31'd0, seen}, 32'd1);
        chk(page_fault == exp_fault, exp_fault ? (exp_reads == 1 ? "R5 fault flag" : "R6 fault flag")
                                               : "R4 no fault", {31'd0, page_fault}, {31'd0, exp_fault});
        chk(paddr == exp_pa, exp_fault ? "R5 R6 zero paddr" : "R4 paddr", paddr, exp_pa);
        chk(nreads == exp_reads, "R5 R6 R7 read count", nreads, exp_reads);
        chk(rlog[0] == da, "R2 R10 directory entry address", rlog[0], da);
        if (exp_reads == 2)
            chk(rlog[1] == ta, "R3 table entry address", rlog[1], ta);
        @(negedge clk);
        chk(done == 1'b0, "R9 done single cycle", {31'd0, done}, 32'd0);
        chk(req_ready == 1'b1, "R9 ready after done", {31'd0, req_ready}, 32'd1);
        chk(nreads == exp_reads, "R7 no read after walk", nreads, exp_reads);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0;
        req_laddr = '0;
        root_base = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1, "R1 req_ready", {31'd0, req_ready}, 32'd1);
        chk(mem_req == 1'b0, "R1 mem_req", {31'd0, mem_req}, 32'd0);
        chk(done == 1'b0, "R1 done", {31'd0, done}, 32'd0);
        chk(page_fault == 1'b0, "R1 page_fault", {31'd0, page_fault}, 32'd0);
        chk(paddr == 32'd0, "R1 paddr", paddr, 32'd0);

        // Sweep all directory indices; R8 latency 0..3 wait cycles.
        for (int i = 0; i < 1024; i++) begin
            logic [31:0] la, rt;
            la = {i[9:0], 10'((i * 37) ^ 10'h155), 12'((i * 113) + 12'h7A1)};
            rt = {20'((i * 7919) ^ 20'h3C3C3), 12'hABC};
            walk(la, rt, i % 4);
        end
        // Edge addresses
        walk(32'h0000_0000, 32'h0000_0000, 0);
        walk(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2);
        walk(32'h0814_7258, 32'h0012_3FFF, 1);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule